// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block does the register work that happens when a simple 32-bit core takes an exception. When an entry request arrives, it receives a kind, a cause code, the faulting PC, and a flag that marks a branch delay slot. It also receives the current Status, Cause and Debug words and the debug-mode flag. On the next clock edge it registers the updated control words and the saved return address for the path that was taken. It also registers the address where fetch must restart.

There are three entry paths, and each has its own return register:
- **Normal path.** General exceptions and external interrupts save into EPC.
- **Error path.** Reset entry saves into ErrorEPC.
- **Debug path.** The six debug-class events save into DEPC.

Instruction fetch and pipeline flush are left to the core. The core takes `vector_o` when `taken_o` pulses and writes the returned Status, Cause and Debug values back into its own state.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On normal-path entry, `epc_o` becomes PC minus 4 and `cause_o[31]` is set when `req_in_slot_i` is high. Otherwise `epc_o` becomes PC and `cause_o[31]` is cleared. PC minus 4 wraps modulo 2^32.
- R2: On normal-path entry, `cause_o[6:2]` takes the entry code. For kind 2 the code is `req_excode_i`; for kind 1 it is 0. Every other bit except bit 31 is copied from `cause_i`.
- R3: On normal-path entry, `status_o` equals `status_i` with bit 1 (exception level) set.
- R4: Kind encoding on `req_kind_i`: 0 reset, 1 external interrupt, 2 general exception, 3 debug single step, 4 debug breakpoint, 5 debug data-load break, 6 debug data-store break, 7 debug instruction break, 8 debug interrupt. For kind 2 the vector is base plus 0x180. The base is 0xBFC00200 when `status_i[22]` (bootstrap) is set and 0x80000000 otherwise.
- R5: For kind 1, the vector is base plus 0x200 when `cause_i[23]` is set and base plus 0x180 when it is clear.
- R6: Kind 1 while `in_debug_i` is high is handled exactly as kind 8. `epc_o` is left unchanged.
- R7: Kinds 3 to 8 take the debug path, which does the following:
  - sets bit (kind minus 3) of `debug_o` on top of `debug_i`;
  - loads `depc_o` with the return address (the kind 3 return address is always PC, with no slot adjustment);
  - sets `dm_o`;
  - passes `status_i` and `cause_i` through;
  - vectors to 0xBFC00480.
- R8: Kind 0 does the following:
  - sets `status_o` to bits 28, 22 and 2 only;
  - loads `random_o` with TLB_ENTRIES minus 1;
  - pulses `watch_clr_o`;
  - loads `errorepc_o` with the return address (PC, or PC minus 4 in a slot);
  - clears `dm_o`;
  - vectors to 0xBFC00000.
- R9: Kinds 9 to 15 pulse `err_o` for one cycle, keep `taken_o` low and leave every other output unchanged.
- R10: After `rst_n` is released, and before any request, every output is zero.
- R11: Outputs change at the clock edge that samples `req_valid_i`. `taken_o`, `err_o` and `watch_clr_o` are high for that one cycle only. On the normal and error paths, `debug_o` and `dm_o` follow `debug_i` and `in_debug_i` (except where R8 clears `dm_o`). Registers that the taken path does not own keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Entry request strobe |
| req_kind_i | input | 4 | Entry kind (see R4) |
| req_excode_i | input | 5 | Cause code for general exceptions |
| req_pc_i | input | 32 | PC of the excepting instruction |
| req_in_slot_i | input | 1 | Instruction sits in a branch delay slot |
| status_i | input | 32 | Current Status word |
| cause_i | input | 32 | Current Cause word |
| debug_i | input | 32 | Current Debug word |
| in_debug_i | input | 1 | Core is in debug mode |
| taken_o | output | 1 | Entry accepted, one-cycle pulse |
| err_o | output | 1 | Unknown kind, one-cycle pulse |
| vector_o | output | 32 | Restart address |
| epc_o | output | 32 | Normal-path return address |
| errorepc_o | output | 32 | Error-path return address |
| depc_o | output | 32 | Debug-path return address |
| status_o | output | 32 | Updated Status word |
| cause_o | output | 32 | Updated Cause word |
| debug_o | output | 32 | Updated Debug word |
| dm_o | output | 1 | Debug mode after entry |
| random_o | output | RAND_W | TLB random index |
| watch_clr_o | output | 1 | Watch register clear pulse |

## Verification
The bench sweeps all sixteen kind codes against all sixteen combinations of delay slot, bootstrap bit, interrupt-vector bit and debug mode. Together these separate:
- the three return registers from one another;
- the two vector bases and the two interrupt offsets;
- the slot adjustment from the single-step exemption;
- the interrupt-to-debug conversion from an ordinary interrupt.

The Status, Cause and Debug inputs vary with each combination, so pass-through and bit preservation are tested against changing values. A zero PC taken in a slot checks the wrap of the minus-4 adjustment. The idle cycle after each request shows that the pulses drop and that an unknown kind leaves all state alone.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int XW    = 32;
  localparam int DBG_W = 6;

  localparam int ST_CU0  = 28;
  localparam int ST_BEV  = 22;
  localparam int ST_ERL  = 2;
  localparam int ST_EXL  = 1;
  localparam int CA_BD   = 31;
  localparam int CA_IV   = 23;
  localparam int CA_CODE = 2;

  typedef enum logic [3:0] {
    K_RESET      = 4'd0,
    K_INTR       = 4'd1,
    K_GENERAL    = 4'd2,
    K_DBG_STEP   = 4'd3,
    K_DBG_SWBRK  = 4'd4,
    K_DBG_DLOAD  = 4'd5,
    K_DBG_DSTORE = 4'd6,
    K_DBG_IBRK   = 4'd7,
    K_DBG_INTR   = 4'd8
  } kind_e;

  typedef enum logic [1:0] {
    PATH_NORMAL = 2'd0,
    PATH_ERROR  = 2'd1,
    PATH_DEBUG  = 2'd2,
    PATH_BAD    = 2'd3
  } path_e;

  function automatic logic [XW-1:0] ret_addr(input logic [XW-1:0] pc,
                                             input logic in_slot,
                                             input logic no_adjust);
    return (in_slot && !no_adjust) ? pc - XW'(4) : pc;
  endfunction

  function automatic logic [XW-1:0] normal_vector(input logic [XW-1:0] boot_base,
                                                  input logic [XW-1:0] norm_base,
                                                  input logic [XW-1:0] gen_ofs,
                                                  input logic [XW-1:0] int_ofs,
                                                  input logic bev,
                                                  input logic use_int_ofs);
    return (bev ? boot_base : norm_base) + (use_int_ofs ? int_ofs : gen_ofs);
  endfunction

  function automatic logic [XW-1:0] cause_update(input logic [XW-1:0] cause,
                                                 input logic [4:0] code,
                                                 input logic in_slot);
    logic [XW-1:0] c;
    c = cause;
    c[CA_CODE +: 5] = code;
    c[CA_BD] = in_slot;
    return c;
  endfunction

endpackage

// File: rtl/exc_entry_classify.sv
module exc_entry_classify
  import exc_entry_pkg::*;
(
  input  logic [3:0]       kind_i,
  input  logic [4:0]       excode_i,
  input  logic             in_debug_i,
  output path_e            path_o,
  output logic             is_intr_o,
  output logic [4:0]       code_o,
  output logic [DBG_W-1:0] dbg_set_o,
  output logic             no_adjust_o
);

  logic [3:0] eff_kind;

  always_comb begin
    eff_kind = (kind_i == K_INTR && in_debug_i) ? K_DBG_INTR : kind_i;
    path_o      = PATH_BAD;
    is_intr_o   = 1'b0;
    code_o      = 5'd0;
    no_adjust_o = 1'b0;
    case (eff_kind)
      K_RESET:   path_o = PATH_ERROR;
      K_INTR:    begin path_o = PATH_NORMAL; is_intr_o = 1'b1; end
      K_GENERAL: begin path_o = PATH_NORMAL; code_o = excode_i; end
      K_DBG_STEP: begin path_o = PATH_DEBUG; no_adjust_o = 1'b1; end
      K_DBG_SWBRK, K_DBG_DLOAD, K_DBG_DSTORE, K_DBG_IBRK, K_DBG_INTR:
        path_o = PATH_DEBUG;
      default: path_o = PATH_BAD;
    endcase
  end

  for (genvar b = 0; b < DBG_W; b++) begin : g_dbg_bit
    assign dbg_set_o[b] = (eff_kind == 4'(int'(K_DBG_STEP) + b));
  end

endmodule

// File: rtl/exc_entry_vector.sv
module exc_entry_vector
  import exc_entry_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [31:0] NORM_BASE = 32'h8000_0000,
  parameter logic [31:0] GEN_OFS   = 32'h0000_0180,
  parameter logic [31:0] INT_OFS   = 32'h0000_0200,
  parameter logic [31:0] DEBUG_VEC = 32'hBFC0_0480
) (
  input  path_e          path_i,
  input  logic           is_intr_i,
  input  logic           bev_i,
  input  logic           iv_i,
  output logic [XW-1:0]  vector_o
);

  always_comb begin
    case (path_i)
      PATH_ERROR: vector_o = RESET_VEC;
      PATH_DEBUG: vector_o = DEBUG_VEC;
      PATH_NORMAL: vector_o = normal_vector(BOOT_BASE, NORM_BASE, GEN_OFS, INT_OFS,
                                            bev_i, is_intr_i && iv_i);
      default: vector_o = '0;
    endcase
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int TLB_ENTRIES = 16,
  parameter int RAND_W      = $clog2(TLB_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [3:0]        req_kind_i,
  input  logic [4:0]        req_excode_i,
  input  logic [31:0]       req_pc_i,
  input  logic              req_in_slot_i,
  input  logic [31:0]       status_i,
  input  logic [31:0]       cause_i,
  input  logic [31:0]       debug_i,
  input  logic              in_debug_i,
  output logic              taken_o,
  output logic              err_o,
  output logic [31:0]       vector_o,
  output logic [31:0]       epc_o,
  output logic [31:0]       errorepc_o,
  output logic [31:0]       depc_o,
  output logic [31:0]       status_o,
  output logic [31:0]       cause_o,
  output logic [31:0]       debug_o,
  output logic              dm_o,
  output logic [RAND_W-1:0] random_o,
  output logic              watch_clr_o
);

  localparam logic [RAND_W-1:0] RAND_TOP = RAND_W'(TLB_ENTRIES - 1);
  localparam logic [31:0] RESET_STATUS = (32'd1 << ST_CU0) | (32'd1 << ST_BEV) |
                                         (32'd1 << ST_ERL);

  path_e            path_w;
  logic             is_intr_w;
  logic [4:0]       code_w;
  logic [DBG_W-1:0] dbg_set_w;
  logic             no_adjust_w;
  logic [31:0]      vec_w;
  logic [31:0]      ret_w;
  logic             take_w;
  logic             bad_w;

  exc_entry_classify u_classify (
    .kind_i      (req_kind_i),
    .excode_i    (req_excode_i),
    .in_debug_i  (in_debug_i),
    .path_o      (path_w),
    .is_intr_o   (is_intr_w),
    .code_o      (code_w),
    .dbg_set_o   (dbg_set_w),
    .no_adjust_o (no_adjust_w)
  );

  exc_entry_vector u_vector (
    .path_i    (path_w),
    .is_intr_i (is_intr_w),
    .bev_i     (status_i[ST_BEV]),
    .iv_i      (cause_i[CA_IV]),
    .vector_o  (vec_w)
  );

  assign ret_w  = ret_addr(req_pc_i, req_in_slot_i, no_adjust_w);
  assign take_w = req_valid_i && (path_w != PATH_BAD);
  assign bad_w  = req_valid_i && (path_w == PATH_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_o     <= 1'b0;
      err_o       <= 1'b0;
      vector_o    <= '0;
      epc_o       <= '0;
      errorepc_o  <= '0;
      depc_o      <= '0;
      status_o    <= '0;
      cause_o     <= '0;
      debug_o     <= '0;
      dm_o        <= 1'b0;
      random_o    <= '0;
      watch_clr_o <= 1'b0;
    end else begin
      taken_o     <= take_w;
      err_o       <= bad_w;
      watch_clr_o <= 1'b0;
      if (take_w) begin
        vector_o <= vec_w;
        case (path_w)
          PATH_NORMAL: begin
            epc_o    <= ret_w;
            cause_o  <= cause_update(cause_i, code_w, req_in_slot_i);
            status_o <= status_i | (32'd1 << ST_EXL);
            debug_o  <= debug_i;
            dm_o     <= in_debug_i;
          end
          PATH_ERROR: begin
            errorepc_o  <= ret_w;
            status_o    <= RESET_STATUS;
            cause_o     <= cause_i;
            debug_o     <= debug_i;
            dm_o        <= 1'b0;
            random_o    <= RAND_TOP;
            watch_clr_o <= 1'b1;
          end
          default: begin
            depc_o   <= ret_w;
            status_o <= status_i;
            cause_o  <= cause_i;
            debug_o  <= debug_i | 32'(dbg_set_w);
            dm_o     <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int RAND_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic [3:0]        req_kind_i,
  input logic [31:0]       req_pc_i,
  input logic              req_in_slot_i,
  input logic              in_debug_i,
  input path_e             path_w,
  input logic              taken_o,
  input logic              err_o,
  input logic [31:0]       epc_o,
  input logic [31:0]       status_o,
  input logic [31:0]       cause_o,
  input logic [31:0]       debug_o,
  input logic              dm_o,
  input logic [RAND_W-1:0] random_o,
  input logic              watch_clr_o
);

  p_epc_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && path_w == PATH_NORMAL && req_in_slot_i) |=>
      (epc_o == $past(req_pc_i) - 32'd4) && cause_o[31]);

  p_exl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && path_w == PATH_NORMAL) |=> status_o[ST_EXL]);

  p_intr_in_debug_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_kind_i == 4'd1 && in_debug_i) |=>
      debug_o[5] && dm_o && $stable(epc_o));

  p_debug_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && path_w == PATH_DEBUG) |=> dm_o && taken_o);

  p_reset_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_kind_i == 4'd0) |=>
      status_o[ST_ERL] && !dm_o && watch_clr_o && (random_o != '0 || RAND_W == 0));

  p_bad_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_kind_i > 4'd8) |=>
      err_o && !taken_o && $stable(epc_o) && $stable(status_o) && $stable(cause_o));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !taken_o && !err_o && !watch_clr_o);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(taken_o && err_o));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.RAND_W(RAND_W)) u_chk (.*);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  localparam int N  = 16;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [3:0]    req_kind_i = '0;
  logic [4:0]    req_excode_i = '0;
  logic [31:0]   req_pc_i = '0;
  logic          req_in_slot_i = 1'b0;
  logic [31:0]   status_i = '0, cause_i = '0, debug_i = '0;
  logic          in_debug_i = 1'b0;
  logic          taken_o, err_o, dm_o, watch_clr_o;
  logic [31:0]   vector_o, epc_o, errorepc_o, depc_o, status_o, cause_o, debug_o;
  logic [RW-1:0] random_o;

  int tests = 0, fails = 0;
  logic done = 1'b0;

  logic [31:0] e_vec, e_epc, e_eepc, e_depc, e_st, e_ca, e_dbg;
  logic        e_dm;
  logic [RW-1:0] e_rand;

  always #10 clk = ~clk;

  exc_entry_ctrl #(.TLB_ENTRIES(N)) u_dut (.*);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic e_tk, input logic e_er,
                           input logic e_wc);
    chk(tag, "taken", 32'(taken_o), 32'(e_tk));
    chk(tag, "err", 32'(err_o), 32'(e_er));
    chk(tag, "watch_clr", 32'(watch_clr_o), 32'(e_wc));
    chk(tag, "vector", vector_o, e_vec);
    chk(tag, "epc", epc_o, e_epc);
    chk(tag, "errorepc", errorepc_o, e_eepc);
    chk(tag, "depc", depc_o, e_depc);
    chk(tag, "status", status_o, e_st);
    chk(tag, "cause", cause_o, e_ca);
    chk(tag, "debug", debug_o, e_dbg);
    chk(tag, "dm", 32'(dm_o), 32'(e_dm));
    chk(tag, "random", 32'(random_o), 32'(e_rand));
  endtask

  initial begin
    #4_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    {e_vec, e_epc, e_eepc, e_depc, e_st, e_ca, e_dbg} = '0;
    e_dm = 1'b0; e_rand = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10", 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < 16; c++) begin
        logic ds, bev, iv, idb, tk, er, wc;
        logic [31:0] pc, ret, base;
        int eff;
        string tag;
        ds = c[0]; bev = c[1]; iv = c[2]; idb = c[3];
        pc = (k == 2 && c == 1) ? 32'h0 : 32'h0040_0000 + 32'(k * 256 + c * 4);
        req_kind_i    = 4'(k);
        req_excode_i  = 5'(k * 3 + c + 1);
        req_pc_i      = pc;
        req_in_slot_i = ds;
        status_i = (32'h0000_FF10 ^ 32'(k * 32'h0101_0000)) & ~32'h0040_0002;
        status_i[22] = bev;
        cause_i  = 32'h8F0F_0F03 ^ 32'(c * 32'h0001_0100);
        cause_i[23] = iv;
        debug_i  = 32'h0000_0300 | 32'(c & 1);
        in_debug_i = idb;
        req_valid_i = 1'b1;

        eff = (k == 1 && idb) ? 8 : k;
        ret = ds ? pc - 32'd4 : pc;
        base = bev ? 32'hBFC0_0200 : 32'h8000_0000;
        tk = 1'b1; er = 1'b0; wc = 1'b0;
        if (eff == 0) begin
          tag = "R8";
          e_vec = 32'hBFC0_0000; e_eepc = ret;
          e_st = 32'h1040_0004; e_ca = cause_i; e_dbg = debug_i;
          e_dm = 1'b0; e_rand = RW'(N - 1); wc = 1'b1;
        end else if (eff == 1 || eff == 2) begin
          tag = (eff == 1) ? "R5" : "R4";
          e_vec = base + ((eff == 1 && iv) ? 32'h200 : 32'h180);
          e_epc = ret;
          e_ca = {ds, cause_i[30:7], (eff == 1) ? 5'd0 : req_excode_i, cause_i[1:0]};
          e_st = status_i + 32'd2;
          e_dbg = debug_i; e_dm = idb;
        end else if (eff <= 8) begin
          tag = (k == 1) ? "R6" : "R7";
          e_vec = 32'hBFC0_0480;
          e_depc = (eff == 3) ? pc : ret;
          e_st = status_i; e_ca = cause_i;
          e_dbg = debug_i | (32'd1 << (eff - 3));
          e_dm = 1'b1;
        end else begin
          tag = "R9";
          tk = 1'b0; er = 1'b1;
        end
        @(negedge clk);
        req_valid_i = 1'b0;
        check_all(tag, tk, er, wc);
        if (eff == 1 || eff == 2) begin
          chk("R1", "slot_epc", epc_o, ds ? pc - 32'd4 : pc);
          chk("R2", "code", 32'(cause_o[6:2]), (eff == 1) ? 32'd0 : 32'(req_excode_i));
          chk("R3", "exl", 32'(status_o[1]), 32'd1);
        end
        @(negedge clk);
        check_all("R11", 1'b0, 1'b0, 1'b0);
      end
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule